// File: doc/BRIEF.md
# Management RAM Window Access Decoder

This block sits in the memory-decode path of a host bridge and steers each processor memory access that lands in the 128 KiB legacy graphics window (0xA0000 to 0xBFFFF) to one of two targets: the video memory port or the protected management RAM port. Accesses outside the window are handed to the ordinary main-memory path. The choice depends on whether the processor reports that it is running in its management mode and on an 8-bit control register held in the block.

The control register is reached at one offset of configuration space (0x9C of the host bridge function). One of its bits opens the protected RAM to accesses made outside management mode. Another bit is a one-way lock: once software sets it, every later configuration write completes but changes nothing, and only a reset clears it. The route is latched one clock after the request, so the three target strobes are registered outputs.

Top module: `smram_window_decoder`

## Requirements
- R1: After reset the control register reads 0x00 and all three target strobes are low.
- R2: A request (read or write strobe high) whose address is below 0xA0000 or above 0xBFFFF raises only `main_sel`, whatever the mode and register value.
- R3: A request inside 0xA0000..0xBFFFF (both ends included) with `mgmt_mode` low and the open bit (bit 6) clear raises only `video_sel`.
- R4: A request inside the window with `mgmt_mode` high raises only `smram_sel`, whether the open bit is set or not.
- R5: A request inside the window with the open bit (bit 6) set raises only `smram_sel` even when `mgmt_mode` is low.
- R6: While the lock bit is clear, a configuration write with `cfg_sel` high at offset 0x9C stores all eight data bits; a write with `cfg_sel` low or at any other offset leaves the register unchanged.
- R7: Once the lock bit (bit 4) is set, every later configuration write leaves all eight register bits unchanged, including the lock bit itself.
- R8: Only reset clears the lock bit; after reset the register is writable again.
- R9: A configuration read with `cfg_sel` high at offset 0x9C returns the current register value in the same cycle, locked or not; reads at other offsets return 0x00.
- R10: The strobes follow a request by exactly one clock, at most one of them is high in any cycle, and a cycle with neither request strobe yields all three low one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears register and strobes |
| req_addr | input | 32 | Physical address of the processor access |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| mgmt_mode | input | 1 | Processor is in management mode |
| cfg_sel | input | 1 | Configuration access targets this function |
| cfg_off | input | 8 | Configuration register offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| video_sel | output | 1 | Access routed to video memory |
| smram_sel | output | 1 | Access routed to protected management RAM |
| main_sel | output | 1 | Access routed to main memory (outside window) |

## Verification
A corrupted control register shows at the ports in two ways: on the very next configuration read at offset 0x9C, and one clock after the next in-window request, where a wrong open bit flips the route between `video_sel` and `smram_sel`. A lock bit that fails to stick is exposed by the first write after locking, since the following read returns the new data instead of the frozen value. A wrong window comparison shows only on requests near 0xA0000 and 0xBFFFF, so both edges and the addresses just outside them are exercised, each observed one clock after the request.

// File: rtl/smram_win_pkg.sv
package smram_win_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE  = 2'd0,
      ROUTE_MAIN  = 2'd1,
      ROUTE_VIDEO = 2'd2,
      ROUTE_SMRAM = 2'd3
   } route_e;

   // Pick the target for one access.
   function automatic route_e route_pick(input logic valid,
                                         input logic in_win,
                                         input logic mgmt,
                                         input logic open_ovr);
      route_e r;
      if (!valid)                r = ROUTE_NONE;
      else if (!in_win)          r = ROUTE_MAIN;
      else if (mgmt || open_ovr) r = ROUTE_SMRAM;
      else                       r = ROUTE_VIDEO;
      return r;
   endfunction

endpackage

// File: rtl/smram_win_match.sv
module smram_win_match #(
   parameter int          ADDR_W   = 32,
   parameter int unsigned WIN_BASE = 32'h000A_0000,
   parameter int unsigned WIN_SIZE = 32'h0002_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win
);
   localparam int SZ_LOG = $clog2(WIN_SIZE);
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
   localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(WIN_SIZE);
   localparam bit IS_POW2 = ((64'd1 << SZ_LOG) == 64'(WIN_SIZE)) &&
                            ((WIN_BASE % WIN_SIZE) == 0);

   generate
      if (IS_POW2 && SZ_LOG < ADDR_W) begin : g_mask
         // Naturally aligned power-of-two window: compare upper bits only.
         assign in_win = (addr[ADDR_W-1:SZ_LOG] == LO[ADDR_W-1:SZ_LOG]);
      end else begin : g_range
         logic [ADDR_W:0] a_ext;
         assign a_ext  = {1'b0, addr};
         assign in_win = (a_ext >= LO) && (a_ext < HI);
      end
   endgenerate
endmodule

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg #(
   parameter int          REG_W    = 8,
   parameter int          OFF_W    = 8,
   parameter int unsigned REG_OFF  = 8'h9C,
   parameter int          LOCK_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sel,
   input  logic [OFF_W-1:0] cfg_off,
   input  logic             cfg_wr,
   input  logic             cfg_rd,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic [REG_W-1:0] ctl_q
);
   localparam logic [OFF_W-1:0] OFF_HIT = OFF_W'(REG_OFF);

   logic hit;
   logic wr_ok;

   assign hit   = cfg_sel && (cfg_off == OFF_HIT);
   assign wr_ok = hit && cfg_wr && !ctl_q[LOCK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl_q <= '0;
      else if (wr_ok) ctl_q <= cfg_wdata;
   end

   assign cfg_rdata = (hit && cfg_rd) ? ctl_q : '0;
endmodule

// File: rtl/smram_route_stage.sv
module smram_route_stage
   import smram_win_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  route_e route_d,
   output logic   video_sel,
   output logic   smram_sel,
   output logic   main_sel
);
   logic [2:0] sel_d;

   always_comb begin
      sel_d = 3'b000;
      unique case (route_d)
         ROUTE_VIDEO: sel_d = 3'b100;
         ROUTE_SMRAM: sel_d = 3'b010;
         ROUTE_MAIN:  sel_d = 3'b001;
         default:     sel_d = 3'b000;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [2:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= 3'b000;
            else        sel_q <= sel_d;
         end
         assign {video_sel, smram_sel, main_sel} = sel_q;
      end else begin : g_comb
         assign {video_sel, smram_sel, main_sel} = sel_d;
      end
   endgenerate
endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
   import smram_win_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int unsigned WIN_BASE = 32'h000A_0000,
   parameter int unsigned WIN_SIZE = 32'h0002_0000,
   parameter int          REG_W    = 8,
   parameter int          OFF_W    = 8,
   parameter int unsigned REG_OFF  = 8'h9C,
   parameter int          OPEN_BIT = 6,
   parameter int          LOCK_BIT = 4,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic              mgmt_mode,
   input  logic              cfg_sel,
   input  logic [OFF_W-1:0]  cfg_off,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic              video_sel,
   output logic              smram_sel,
   output logic              main_sel
);
   // Elaboration-time parameter checks.
   generate
      if (OPEN_BIT >= REG_W || LOCK_BIT >= REG_W || OPEN_BIT == LOCK_BIT) begin : g_bad_bits
         $error("control bit positions invalid for register width");
      end
      if (WIN_SIZE == 0) begin : g_bad_size
         $error("window size must be nonzero");
      end
      if (OFF_W < 1 || REG_OFF >= (64'd1 << OFF_W)) begin : g_bad_off
         $error("register offset does not fit the offset width");
      end
   endgenerate

   logic [REG_W-1:0] ctl_q;
   logic             in_win;
   logic             req_valid;
   route_e           route_d;

   smram_ctl_reg #(
      .REG_W   (REG_W),
      .OFF_W   (OFF_W),
      .REG_OFF (REG_OFF),
      .LOCK_BIT(LOCK_BIT)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_sel  (cfg_sel),
      .cfg_off  (cfg_off),
      .cfg_wr   (cfg_wr),
      .cfg_rd   (cfg_rd),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .ctl_q    (ctl_q)
   );

   smram_win_match #(
      .ADDR_W  (ADDR_W),
      .WIN_BASE(WIN_BASE),
      .WIN_SIZE(WIN_SIZE)
   ) u_match (
      .addr  (req_addr),
      .in_win(in_win)
   );

   assign req_valid = req_rd | req_wr;
   assign route_d   = route_pick(req_valid, in_win, mgmt_mode, ctl_q[OPEN_BIT]);

   smram_route_stage #(
      .OUT_REG(OUT_REG)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .route_d  (route_d),
      .video_sel(video_sel),
      .smram_sel(smram_sel),
      .main_sel (main_sel)
   );
endmodule

// File: rtl/smram_win_chk.sv
module smram_win_chk #(
   parameter int          ADDR_W   = 32,
   parameter int unsigned WIN_BASE = 32'h000A_0000,
   parameter int unsigned WIN_SIZE = 32'h0002_0000,
   parameter int          REG_W    = 8,
   parameter int          OPEN_BIT = 6,
   parameter int          LOCK_BIT = 4,
   parameter bit          OUT_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_rd,
   input logic              req_wr,
   input logic              mgmt_mode,
   input logic [REG_W-1:0]  ctl_q,
   input logic              video_sel,
   input logic              smram_sel,
   input logic              main_sel
);
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
   localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(WIN_SIZE);

   logic req_v;
   logic win;
   assign req_v = req_rd | req_wr;
   assign win   = ({1'b0, req_addr} >= LO) && ({1'b0, req_addr} < HI);

   AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({video_sel, smram_sel, main_sel})); // R10
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[LOCK_BIT] |=> $stable(ctl_q)); // R7

   generate
      if (OUT_REG) begin : g_lat1
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_v |=> !(video_sel || smram_sel || main_sel)); // R10
         AST_OUTSIDE_MAIN: assert property (@(posedge clk) disable iff (!rst_n) (req_v && !win) |=> main_sel); // R2
         AST_PLAIN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && !mgmt_mode && !ctl_q[OPEN_BIT]) |=> video_sel); // R3
         AST_MGMT_SMRAM: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && mgmt_mode) |=> smram_sel); // R4
         AST_OPEN_SMRAM: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && ctl_q[OPEN_BIT]) |=> smram_sel); // R5
      end else begin : g_lat0
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_v |-> !(video_sel || smram_sel || main_sel)); // R10
         AST_OUTSIDE_MAIN: assert property (@(posedge clk) disable iff (!rst_n) (req_v && !win) |-> main_sel); // R2
         AST_PLAIN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && !mgmt_mode && !ctl_q[OPEN_BIT]) |-> video_sel); // R3
         AST_MGMT_SMRAM: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && mgmt_mode) |-> smram_sel); // R4
         AST_OPEN_SMRAM: assert property (@(posedge clk) disable iff (!rst_n) (req_v && win && ctl_q[OPEN_BIT]) |-> smram_sel); // R5
      end
   endgenerate
endmodule

bind smram_window_decoder smram_win_chk #(
   .ADDR_W  (ADDR_W),
   .WIN_BASE(WIN_BASE),
   .WIN_SIZE(WIN_SIZE),
   .REG_W   (REG_W),
   .OPEN_BIT(OPEN_BIT),
   .LOCK_BIT(LOCK_BIT),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_addr (req_addr),
   .req_rd   (req_rd),
   .req_wr   (req_wr),
   .mgmt_mode(mgmt_mode),
   .ctl_q    (ctl_q),
   .video_sel(video_sel),
   .smram_sel(smram_sel),
   .main_sel (main_sel)
);

// File: tb/tb_smram_window_decoder.sv
module tb_smram_window_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_rd = 1'b0;
   logic        req_wr = 1'b0;
   logic        mgmt_mode = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_off = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        video_sel, smram_sel, main_sel;

   always #2 clk = ~clk;   // 250 MHz

   smram_window_decoder dut (
      .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
      .mgmt_mode(mgmt_mode), .cfg_sel(cfg_sel), .cfg_off(cfg_off), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .video_sel(video_sel), .smram_sel(smram_sel), .main_sel(main_sel)
   );

   typedef struct {
      logic [2:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t   sb_q[$];
   int         n_run = 0;
   int         n_fail = 0;
   logic [7:0] model_ctl = 8'h00;
   bit         done = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Expected strobes {video, smram, main} from the requirements.
   function automatic logic [2:0] expect_route(input logic [31:0] a, input logic rd,
                                               input logic wr, input logic mgmt);
      if (!(rd || wr)) return 3'b000;                        // R10
      if (a < 32'h000A_0000 || a > 32'h000B_FFFF) return 3'b001; // R2
      if (mgmt || model_ctl[6]) return 3'b010;               // R4 / R5
      return 3'b100;                                         // R3
   endfunction

   // Driver: one request cycle, expectation pushed to the scoreboard.
   task automatic drive_req(input logic [31:0] a, input logic rd, input logic wr,
                            input logic mgmt, input string tag);
      sb_item_t it;
      @(negedge clk);
      cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
      req_addr = a; req_rd = rd; req_wr = wr; mgmt_mode = mgmt;
      it.exp = expect_route(a, rd, wr, mgmt);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic cfg_write(input logic sel, input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
      cfg_sel = sel; cfg_off = off; cfg_wr = 1'b1; cfg_rd = 1'b0; cfg_wdata = d;
      if (sel && off == 8'h9C && !model_ctl[4]) model_ctl = d;  // R6 / R7
   endtask

   task automatic cfg_read(input logic [7:0] off, input logic [7:0] exp, input string tag);
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
      cfg_sel = 1'b1; cfg_off = off; cfg_wr = 1'b0; cfg_rd = 1'b1;
      #1;
      check(tag, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_rd = 1'b0; req_wr = 1'b0; cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
      model_ctl = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: compare strobes one clock after each driven request.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, 32'({video_sel, smram_sel, main_sel}), 32'(it.exp));
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 strobes in reset", 32'({video_sel, smram_sel, main_sel}), 32'h0);
      check("R1 register in reset", 32'(dut.cfg_rdata), 32'h0);
      rst_n = 1'b1;
      cfg_read(8'h9C, 8'h00, "R1 register after reset");

      drive_req(32'h0009_FFFF, 1'b1, 1'b0, 1'b0, "R2 just below window");
      drive_req(32'h000C_0000, 1'b0, 1'b1, 1'b0, "R2 just above window");
      drive_req(32'h0000_1234, 1'b1, 1'b0, 1'b0, "R2 low memory");
      drive_req(32'h000A_0000, 1'b1, 1'b0, 1'b0, "R3 window base");
      drive_req(32'h000B_FFFF, 1'b0, 1'b1, 1'b0, "R3 window top");
      drive_req(32'h000B_8000, 1'b1, 1'b0, 1'b0, "R3 window middle");
      drive_req(32'h000A_8000, 1'b0, 1'b0, 1'b0, "R10 idle cycle");
      drive_req(32'h000A_8000, 1'b1, 1'b0, 1'b1, "R4 management mode in window");
      drive_req(32'h0005_0000, 1'b1, 1'b0, 1'b1, "R2 management mode outside window");

      cfg_write(1'b1, 8'h9D, 8'h40);
      cfg_read(8'h9C, 8'h00, "R6 write at wrong offset ignored");
      cfg_read(8'h9D, 8'h00, "R9 read at other offset");
      cfg_write(1'b0, 8'h9C, 8'h40);
      cfg_read(8'h9C, 8'h00, "R6 write without select ignored");

      cfg_write(1'b1, 8'h9C, 8'h40);
      cfg_read(8'h9C, 8'h40, "R6 open bit stored");
      drive_req(32'h000A_8000, 1'b1, 1'b0, 1'b0, "R5 open bit outside management mode");
      drive_req(32'h000B_FFFF, 1'b0, 1'b1, 1'b0, "R5 open bit window top");
      drive_req(32'h000C_0000, 1'b1, 1'b0, 1'b0, "R2 open bit outside window");

      cfg_write(1'b1, 8'h9C, 8'h2B);
      cfg_read(8'h9C, 8'h2B, "R6 all bits stored");
      drive_req(32'h000A_0000, 1'b1, 1'b0, 1'b0, "R3 open bit cleared");

      cfg_write(1'b1, 8'h9C, 8'h50);
      cfg_read(8'h9C, 8'h50, "R7 lock written");
      cfg_write(1'b1, 8'h9C, 8'h00);
      cfg_read(8'h9C, 8'h50, "R7 write while locked ignored");
      cfg_write(1'b1, 8'h9C, 8'h2F);
      cfg_read(8'h9C, 8'h50, "R9 read while locked");
      drive_req(32'h000A_8000, 1'b1, 1'b0, 1'b0, "R5 locked open bit still routes");
      drive_req(32'h000A_8000, 1'b0, 1'b1, 1'b1, "R4 management mode while locked");

      do_reset();
      cfg_read(8'h9C, 8'h00, "R8 reset clears lock");
      cfg_write(1'b1, 8'h9C, 8'h05);
      cfg_read(8'h9C, 8'h05, "R8 writable after reset");
      drive_req(32'h000A_8000, 1'b1, 1'b0, 1'b0, "R3 video after reset");
      drive_req(32'h000A_8000, 1'b1, 1'b0, 1'b1, "R4 management mode open clear");
      drive_req(32'h000A_8000, 1'b0, 1'b0, 1'b1, "R10 idle with management mode");

      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0; cfg_rd = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule